// File: doc/BRIEF.md
# Horizontally Microcoded Queue-to-Queue Processing Element

This block is one programmable stage of a streaming pipeline. It fetches one 64-bit horizontal microinstruction per cycle from a 64-entry control store. There is no instruction decode: each field of the word drives one piece of the datapath directly. In one cycle a microinstruction can:

- take a word from the input stream;
- form an address and perform one read or one write on a word-wide synchronous SRAM port;
- cut a bit field out of a source word, apply an ALU operation to it, and merge the result into a register;
- offer the merged word on the output stream;
- choose the next control-store address.

The control store is loaded through a simple write port while reset is asserted. Execution starts at address 0 when reset is released.

Both streams use valid/ready. An instruction that needs an input word waits until `in_valid` is high. An instruction that produces an output word waits until `out_ready` is high. While it waits, the instruction has no effect at all: no register write, no SRAM access, no program-counter change, and no handshake on the other stream. `out_valid` does not depend on `out_ready`. Once raised, it stays high with the same data until the word is accepted, provided the input source keeps `in_valid` and `in_data` steady while it waits.

Top module: `ucode_pe`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `mem_en` are 0, and writes on the load port (`cs_we`, `cs_addr`, `cs_wdata`) fill the control store. When reset is released, all eight 32-bit registers are zero and execution starts at control-store address 0.
- R2: A load-port write while `rst_n` is high leaves the control store unchanged.
- R3: The microinstruction bit fields, from MSB to LSB, are:
  - [63] take input;
  - [62] produce output;
  - [61:60] SRAM op (0 none, 1 read, 2 write);
  - [59] extract source (1 = input word, 0 = register);
  - [58:56] source register;
  - [55:53] destination register;
  - [52:48] extract position;
  - [47:43] field width minus one;
  - [42:38] insert position;
  - [37:34] ALU op;
  - [33:26] 8-bit immediate;
  - [25:23] address register;
  - [22:15] address offset;
  - [14] register write enable;
  - [13:12] next-address condition;
  - [11:6] unused;
  - [5:0] next address.
- R4: The field is F = (source >> position) masked to the width. The ALU result R is masked to the same width. The merged word is the destination register with those width bits at the insert position replaced by R. When the write enable is set, the merged word is written to the destination register. The merged word is also the output data and the SRAM write data.
- R5: ALU ops, with the immediate zero-extended: 0 pass F; 1 F+imm; 2 F−imm; 3 F AND imm; 4 F OR imm; 5 F XOR imm; 6 imm; 7 NOT F. Arithmetic wraps within the field width.
- R6: `in_ready` is high only when the instruction takes input and either produces no output or `out_ready` is high. A word is consumed when `in_valid` and `in_ready` are both high.
- R7: If the instruction takes input and `in_valid` is low, it stalls. `out_valid` and `mem_en` stay 0, no register changes, and the same instruction is retried.
- R8: If the instruction produces output and `out_ready` is low, it stalls. `out_valid` stays high with the data unchanged, `in_ready` is 0, and `mem_en` is 0.
- R9: The SRAM address is (low MEM_AW bits of the address register + offset) modulo 2^MEM_AW.
- R10: Data from an SRAM read lands in register 7 at the end of the cycle after the read is issued. The earliest instruction that can use it is the second one after the read. If that landing coincides with an ALU write to register 7, the read data wins.
- R11: Next address: condition 0 gives PC+1; 1 jumps to the next-address field; 2 jumps when the masked R is zero, otherwise PC+1; 3 jumps when the masked R is nonzero, otherwise PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; control store loadable while low |
| cs_we | input | 1 | Control-store load strobe |
| cs_addr | input | 6 | Control-store load address |
| cs_wdata | input | 64 | Microinstruction to load |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | PE consumes the input word this cycle |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output word |
| mem_en | output | 1 | SRAM access this cycle |
| mem_we | output | 1 | SRAM access is a write |
| mem_addr | output | MEM_AW | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, valid the cycle after a read |

## Verification
The bench checks several behaviours:

- **Field arithmetic.** It drives a field increment that overflows its 8-bit width. A design that carried the overflow into neighbouring bits would corrupt the merged word.
- **Stalls on either stream.** It holds each stream back for several cycles. A design with partial side effects would write the SRAM, advance the PC or update the accumulator register twice.
- **SRAM addressing and read return.** It uses an address register whose low bits wrap past the top of the address space. It also aims an ALU write at register 7 in the same cycle a read returns there. Wrong wrapping or wrong write priority shows up in the word read back.
- **Load port after reset.** It tries a control-store write after reset is released. A design that honoured it would change the branch target's output.

// File: rtl/ucode_pe_pkg.sv
package ucode_pe_pkg;
  localparam int UPE_DW       = 32;
  localparam int UPE_PW       = $clog2(UPE_DW);
  localparam int UPE_NREG     = 8;
  localparam int UPE_RW       = $clog2(UPE_NREG);
  localparam int UPE_CS_DEPTH = 64;
  localparam int UPE_CSAW     = $clog2(UPE_CS_DEPTH);
  localparam int UPE_UIW      = 64;
  localparam int UPE_IMMW     = 8;

  typedef enum logic [1:0] {
    MOP_NONE  = 2'd0,
    MOP_READ  = 2'd1,
    MOP_WRITE = 2'd2,
    MOP_RSVD  = 2'd3
  } mem_op_e;

  typedef enum logic [3:0] {
    ALU_PASS = 4'd0,
    ALU_ADD  = 4'd1,
    ALU_SUB  = 4'd2,
    ALU_AND  = 4'd3,
    ALU_OR   = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_IMM  = 4'd6,
    ALU_NOT  = 4'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    NXT_SEQ  = 2'd0,
    NXT_JMP  = 2'd1,
    NXT_ZERO = 2'd2,
    NXT_NZ   = 2'd3
  } next_cond_e;

  typedef struct packed {
    logic                 take_in;
    logic                 give_out;
    mem_op_e              mop;
    logic                 src_is_in;
    logic [UPE_RW-1:0]    src_reg;
    logic [UPE_RW-1:0]    dst_reg;
    logic [UPE_PW-1:0]    ex_pos;
    logic [UPE_PW-1:0]    width_m1;
    logic [UPE_PW-1:0]    in_pos;
    alu_op_e              alu;
    logic [UPE_IMMW-1:0]  imm;
    logic [UPE_RW-1:0]    areg;
    logic [7:0]           aoff;
    logic                 reg_we;
    next_cond_e           cond;
    logic [5:0]           unused;
    logic [UPE_CSAW-1:0]  next;
  } uinstr_t;
endpackage

// File: rtl/upe_store.sv
module upe_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             load_en,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (load_en && we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/upe_bitops.sv
module upe_bitops
  import ucode_pe_pkg::*;
#(
  parameter int DW   = UPE_DW,
  parameter int IMMW = UPE_IMMW,
  localparam int PW  = $clog2(DW)
) (
  input  logic [DW-1:0]   src,
  input  logic [DW-1:0]   dst,
  input  logic [PW-1:0]   ex_pos,
  input  logic [PW-1:0]   width_m1,
  input  logic [PW-1:0]   in_pos,
  input  alu_op_e         op,
  input  logic [IMMW-1:0] imm,
  output logic [DW-1:0]   merged,
  output logic            res_zero
);
  logic [PW:0]   width;
  logic [DW-1:0] mask, field, opnd, res, res_m;

  assign width = {1'b0, width_m1} + (PW+1)'(1);
  assign mask  = (width == (PW+1)'(DW)) ? '1 : ((DW'(1) << width) - DW'(1));
  assign field = (src >> ex_pos) & mask;
  assign opnd  = DW'(imm);

  always_comb begin
    case (op)
      ALU_PASS: res = field;
      ALU_ADD:  res = field + opnd;
      ALU_SUB:  res = field - opnd;
      ALU_AND:  res = field & opnd;
      ALU_OR:   res = field | opnd;
      ALU_XOR:  res = field ^ opnd;
      ALU_IMM:  res = opnd;
      ALU_NOT:  res = ~field;
      default:  res = field;
    endcase
  end

  assign res_m    = res & mask;
  assign res_zero = (res_m == '0);
  assign merged   = (dst & ~(mask << in_pos)) | (res_m << in_pos);
endmodule

// File: rtl/upe_seq.sv
module upe_seq
  import ucode_pe_pkg::*;
#(
  parameter int DEPTH = UPE_CS_DEPTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  next_cond_e    cond,
  input  logic [AW-1:0] target,
  input  logic          res_zero,
  output logic [AW-1:0] pc
);
  logic take;

  always_comb begin
    case (cond)
      NXT_JMP:  take = 1'b1;
      NXT_ZERO: take = res_zero;
      NXT_NZ:   take = !res_zero;
      default:  take = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (fire) pc <= take ? target : pc + AW'(1);
  end

  // R1
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc == '0));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pc));
endmodule

// File: rtl/ucode_pe.sv
module ucode_pe
  import ucode_pe_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int RD_REG = UPE_NREG - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_we,
  input  logic [UPE_CSAW-1:0] cs_addr,
  input  logic [UPE_UIW-1:0]  cs_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [UPE_DW-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [UPE_DW-1:0]   out_data,
  output logic                mem_en,
  output logic                mem_we,
  output logic [MEM_AW-1:0]   mem_addr,
  output logic [UPE_DW-1:0]   mem_wdata,
  input  logic [UPE_DW-1:0]   mem_rdata
);
  logic [UPE_CSAW-1:0] pc;
  logic [UPE_UIW-1:0]  cs_word;
  uinstr_t             u;
  logic [UPE_DW-1:0]   rf [UPE_NREG];
  logic [UPE_DW-1:0]   src_w, merged;
  logic                res_zero, in_ok, out_ok, fire, rd_pend;

  upe_store #(.DEPTH(UPE_CS_DEPTH), .WIDTH(UPE_UIW)) u_store (
    .clk(clk), .load_en(!rst_n), .we(cs_we), .waddr(cs_addr),
    .wdata(cs_wdata), .raddr(pc), .rdata(cs_word)
  );

  assign u = uinstr_t'(cs_word);

  assign in_ok  = !u.take_in  || in_valid;
  assign out_ok = !u.give_out || out_ready;
  assign fire   = rst_n && in_ok && out_ok;

  assign in_ready  = rst_n && u.take_in  && out_ok;
  assign out_valid = rst_n && u.give_out && in_ok;

  assign src_w = u.src_is_in ? in_data : rf[u.src_reg];

  upe_bitops #(.DW(UPE_DW), .IMMW(UPE_IMMW)) u_bits (
    .src(src_w), .dst(rf[u.dst_reg]), .ex_pos(u.ex_pos),
    .width_m1(u.width_m1), .in_pos(u.in_pos), .op(u.alu), .imm(u.imm),
    .merged(merged), .res_zero(res_zero)
  );

  upe_seq #(.DEPTH(UPE_CS_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cond(u.cond),
    .target(u.next), .res_zero(res_zero), .pc(pc)
  );

  assign out_data  = merged;
  assign mem_en    = fire && (u.mop == MOP_READ || u.mop == MOP_WRITE);
  assign mem_we    = fire && (u.mop == MOP_WRITE);
  assign mem_addr  = rf[u.areg][MEM_AW-1:0] + MEM_AW'(u.aoff);
  assign mem_wdata = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= fire && (u.mop == MOP_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < UPE_NREG; i++) rf[i] <= '0;
    end else begin
      for (int i = 0; i < UPE_NREG; i++) begin
        if (rd_pend && i == RD_REG)
          rf[i] <= mem_rdata;
        else if (fire && u.reg_we && u.dst_reg == UPE_RW'(i))
          rf[i] <= merged;
      end
    end
  end

  // R6
  deq_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (!out_valid || out_ready));

  // R7
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u.take_in && !in_valid) |-> (!mem_en && !out_valid));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid) |=> out_valid);

  // R10
  load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> $past(mem_en && !mem_we));
endmodule

// File: tb/ucode_pe_test.sv
module ucode_pe_test;
  import ucode_pe_pkg::*;

  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic cs_we = 0;
  logic [5:0] cs_addr = '0;
  logic [63:0] cs_wdata = '0;
  logic in_valid = 0, out_ready = 0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, mem_en, mem_we;
  logic [31:0] out_data, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] last_waddr = '0;
  logic [31:0] smem [1024];
  logic [63:0] prog [64];
  int n_chk = 0, n_bad = 0;
  logic [31:0] acc;

  always #10 clk = ~clk;

  ucode_pe #(.MEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_addr(cs_addr),
    .cs_wdata(cs_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        smem[mem_addr] <= mem_wdata;
        last_waddr <= mem_addr;
      end else begin
        mem_rdata <= smem[mem_addr];
      end
    end
  end

  function automatic logic [63:0] mk(
    input logic ti, input logic go, input logic [1:0] mop, input logic sin,
    input logic [2:0] sreg, input logic [2:0] dreg, input logic [4:0] epos,
    input int wid, input logic [4:0] ipos, input logic [3:0] alu,
    input logic [7:0] imm, input logic [2:0] areg, input logic [7:0] aoff,
    input logic we, input logic [1:0] cond, input logic [5:0] nxt);
    logic [4:0] wm1;
    wm1 = 5'(wid - 1);
    return {ti, go, mop, sin, sreg, dreg, epos, wm1, ipos, alu, imm,
            areg, aoff, we, cond, 6'd0, nxt};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_prog(input int n);
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0;
    for (int i = 0; i < n; i++) begin
      cs_we = 1; cs_addr = 6'(i); cs_wdata = prog[i];
      @(negedge clk);
    end
    cs_we = 0;
    #1;
    chk({29'd0, in_ready, out_valid, mem_en}, 32'd0, "R1 outputs idle in reset");
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic xfer(input logic [31:0] din, input logic [31:0] exp, input string tag);
    int w = 0;
    @(negedge clk); in_valid = 1; in_data = din; out_ready = 1; #1;
    while (!(in_ready && out_valid) && w < 100) begin @(negedge clk); #1; w++; end
    chk(out_data, exp, tag);
    @(posedge clk); #1; in_valid = 0; out_ready = 0;
  endtask

  task automatic put_in(input logic [31:0] din);
    int w = 0;
    @(negedge clk); in_valid = 1; in_data = din; out_ready = 0; #1;
    while (!in_ready && w < 100) begin @(negedge clk); #1; w++; end
    @(posedge clk); #1; in_valid = 0;
  endtask

  task automatic get_out(input logic [31:0] exp, input string tag);
    int w = 0;
    @(negedge clk); out_ready = 1; #1;
    while (!out_valid && w < 100) begin @(negedge clk); #1; w++; end
    chk(out_data, exp, tag);
    @(posedge clk); #1; out_ready = 0;
  endtask

  function automatic logic [31:0] acc_next(input logic [31:0] a, input logic [31:0] din);
    logic [7:0] f;
    f = 8'(din >> 4) + 8'd1;
    return (a & ~32'h0000_FF00) | {16'd0, f, 8'd0};
  endfunction

  task automatic t_stream;
    prog[0] = mk(1, 1, 2'd2, 1, 3'd0, 3'd1, 5'd4, 8, 5'd8, 4'd1, 8'd1,
                 3'd0, 8'h10, 1, 2'd1, 6'd0);
    load_prog(1);
    acc = 32'd0;
    acc = acc_next(acc, 32'h1234_5678);
    xfer(32'h1234_5678, acc, "R1 R3 R4 first result from zeroed register");
    chk(acc, 32'h0000_6800, "R4 field insert value");
    acc = acc_next(acc, 32'hFFFF_FFF0);
    xfer(32'hFFFF_FFF0, acc, "R5 add wraps within field width");
    chk(smem[10'h10], acc, "R9 merged word written to SRAM at reg+offset");
  endtask

  task automatic t_stall_empty;
    @(negedge clk); in_valid = 0; out_ready = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk({30'd0, out_valid, mem_en}, 32'd0, "R7 no output or SRAM access while input empty");
      @(negedge clk);
    end
    out_ready = 0;
    acc = acc_next(acc, 32'h0000_0ABC);
    xfer(32'h0000_0ABC, acc, "R7 register unchanged by stalled cycles");
  endtask

  task automatic t_stall_full;
    logic [31:0] d0;
    @(negedge clk); in_valid = 1; in_data = 32'h0000_0120; out_ready = 0; #1;
    d0 = out_data;
    chk({29'd0, out_valid, in_ready, mem_en}, 32'd4, "R8 valid held, no dequeue, no SRAM while blocked");
    chk(d0, acc_next(acc, 32'h0000_0120), "R8 offered data");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(out_data, d0, "R8 data stable while blocked");
      chk({31'd0, in_ready}, 32'd0, "R6 in_ready low while output blocked");
    end
    out_ready = 1; #1;
    chk({31'd0, in_ready}, 32'd1, "R6 in_ready rises with out_ready");
    @(posedge clk); #1; in_valid = 0; out_ready = 0;
    acc = acc_next(acc, 32'h0000_0120);
    acc = acc_next(acc, 32'h0000_0340);
    xfer(32'h0000_0340, acc, "R8 blocked instruction applied exactly once");
  endtask

  task automatic t_memory_branch;
    prog[0] = mk(1, 0, 2'd0, 1, 3'd0, 3'd2, 5'd0, 32, 5'd0, 4'd0, 8'd0, 3'd0, 8'd0, 1, 2'd0, 6'd0);
    prog[1] = mk(1, 0, 2'd2, 1, 3'd0, 3'd3, 5'd0, 32, 5'd0, 4'd0, 8'd0, 3'd2, 8'd5, 0, 2'd0, 6'd0);
    prog[2] = mk(0, 0, 2'd1, 0, 3'd0, 3'd0, 5'd0, 32, 5'd0, 4'd0, 8'd0, 3'd2, 8'd5, 0, 2'd0, 6'd0);
    prog[3] = mk(0, 0, 2'd0, 0, 3'd0, 3'd7, 5'd0, 32, 5'd0, 4'd6, 8'h55, 3'd0, 8'd0, 1, 2'd0, 6'd0);
    prog[4] = mk(0, 1, 2'd0, 0, 3'd7, 3'd0, 5'd0, 32, 5'd0, 4'd0, 8'd0, 3'd0, 8'd0, 0, 2'd0, 6'd0);
    prog[5] = mk(1, 0, 2'd0, 1, 3'd0, 3'd0, 5'd0, 8, 5'd0, 4'd0, 8'd0, 3'd0, 8'd0, 0, 2'd2, 6'd7);
    prog[6] = mk(0, 1, 2'd0, 0, 3'd0, 3'd0, 5'd0, 32, 5'd0, 4'd6, 8'hA1, 3'd0, 8'd0, 0, 2'd1, 6'd5);
    prog[7] = mk(0, 1, 2'd0, 0, 3'd0, 3'd0, 5'd0, 32, 5'd0, 4'd6, 8'hB2, 3'd0, 8'd0, 0, 2'd1, 6'd5);
    load_prog(8);
    put_in(32'hFFFF_FFFE);
    put_in(32'hCAFE_0001);
    chk(32'(last_waddr), 32'd3, "R9 address wraps modulo 2^MEM_AW");
    chk(smem[3], 32'hCAFE_0001, "R9 SRAM write data");
    get_out(32'hCAFE_0001, "R10 read data in reg 7 and wins over same-cycle write");
    put_in(32'h0000_0100);
    get_out(32'h0000_00B2, "R11 zero-condition branch taken");
    put_in(32'h0000_0037);
    get_out(32'h0000_00A1, "R11 zero-condition falls through, jump back");
    @(negedge clk);
    cs_we = 1; cs_addr = 6'd7;
    cs_wdata = mk(0, 1, 2'd0, 0, 3'd0, 3'd0, 5'd0, 32, 5'd0, 4'd6, 8'hEE, 3'd0, 8'd0, 0, 2'd1, 6'd5);
    @(negedge clk); cs_we = 0;
    put_in(32'h0000_0200);
    get_out(32'h0000_00B2, "R2 load port ignored out of reset");
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) smem[i] = '0;
    t_stream();
    t_stall_empty();
    t_stall_full();
    t_memory_branch();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule